// File: doc/BRIEF.md
# Paged Address Translator with Per-Page Access Control

This block turns a 16-bit virtual address into a 15-bit physical address using a page table of sixteen entries held on chip. The top four address bits select an entry. The low twelve bits are the byte offset and pass through unchanged. Each entry stores a 3-bit frame number and a set of status bits:

- a present flag;
- read, write and execute permissions;
- a cache-inhibit flag;
- a used flag;
- a dirty flag.

A configuration port writes one entry per cycle. A request port presents a virtual address, an access kind and a valid strobe. One cycle later the block answers with a response pulse. The response carries either a physical address or exactly one fault indication.

A successful access sets the entry's used flag. A successful write also sets its dirty flag. Each response reports the entry's used and dirty flags as they stand after that access, so the bookkeeping can be seen at the ports. Rewriting an entry clears both flags. If a configuration write and a request hit the same entry in the same cycle, the configuration write wins the stored state. The response is still computed from the entry as it stood before that write.

Top module: `pgtbl_xlate`

## Requirements
- R1: After reset, rsp_valid is low and every entry is absent, so any request gets a page-fault response.
- R2: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high, and low otherwise. Back-to-back requests give back-to-back responses.
- R3: On a successful access the physical address is frame*4096 plus vaddr[11:0]. The entry index is vaddr[15:12].
- R4: A request to an entry whose present flag is clear gives rsp_pgfault=1 and rsp_protfault=0. In that case rsp_paddr is 0 and rsp_nocache is 0.
- R5: A request to a present entry gives rsp_protfault=1, with rsp_paddr=0 and rsp_nocache=0, when its access kind is not permitted. The kind encodings are: 0 is a read and needs the read permission, 1 is a write and needs the write permission, 2 is a fetch and needs the execute permission, and 3 is always refused.
- R6: When an entry is absent and the access kind is also not permitted, only rsp_pgfault is raised.
- R7: A fault-free access sets the entry's used flag. rsp_used reports the flag after the access.
- R8: A fault-free write (kind 1) sets the entry's dirty flag. Reads and fetches leave the dirty flag as it was. rsp_dirty reports the flag after the access.
- R9: A faulting access leaves the used and dirty flags unchanged. The response reports their stored values.
- R10: A configuration write replaces the entry's frame, present, permission and cache-inhibit fields, and clears its used and dirty flags.
- R11: On a fault-free access, rsp_nocache reports the entry's cache-inhibit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one page-table entry |
| cfg_idx | input | 4 | Entry index to write |
| cfg_frame | input | 3 | Frame number for the entry |
| cfg_present | input | 1 | Present flag |
| cfg_rd | input | 1 | Read permission |
| cfg_wr | input | 1 | Write permission |
| cfg_ex | input | 1 | Execute permission |
| cfg_nocache | input | 1 | Cache-inhibit flag |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 15 | Physical address, 0 on a fault |
| rsp_pgfault | output | 1 | Entry absent |
| rsp_protfault | output | 1 | Access kind not permitted |
| rsp_nocache | output | 1 | Cache-inhibit flag of the translated page |
| rsp_used | output | 1 | Entry used flag after this access |
| rsp_dirty | output | 1 | Entry dirty flag after this access |

## Verification
The checker watches every cycle for the following:

- the one-cycle request-to-response pulse;
- the two fault flags never being raised together;
- a zeroed address on every fault;
- the offset passing through on success;
- a successful access always reporting used, and a successful write always reporting dirty.

Some behaviour needs a model of the table, so only the bench's sweeps can show it. That covers:

- the frame selected for each page;
- which of the sixteen permission and present combinations refuse which access kind;
- used and dirty flags surviving faults;
- their clearing when an entry is rewritten.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic present;
    logic can_rd;
    logic can_wr;
    logic can_ex;
    logic nocache;
    logic used;
    logic dirty;
  } pte_flags_t;

  // Permission decision for one access kind against one entry's rights.
  function automatic logic kind_permitted(input pte_flags_t f, input logic [1:0] kind);
    logic ok;
    case (kind)
      ACC_READ:  ok = f.can_rd;
      ACC_WRITE: ok = f.can_wr;
      ACC_FETCH: ok = f.can_ex;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Physical address assembly: frame placed directly above the offset.
  function automatic logic [31:0] join_frame(input logic [15:0] frame,
                                             input logic [15:0] offset,
                                             input int unsigned off_w);
    logic [31:0] hi;
    logic [31:0] lo;
    hi = 32'(frame) << off_w;
    lo = 32'(offset) & ((32'd1 << off_w) - 32'd1);
    return hi | lo;
  endfunction

endpackage

// File: rtl/pt_store.sv
module pt_store
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PFN_W-1:0] wr_frame,
  input  logic             wr_present,
  input  logic             wr_rd,
  input  logic             wr_wr,
  input  logic             wr_ex,
  input  logic             wr_nocache,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [PFN_W-1:0] lk_frame,
  output pte_flags_t       lk_flags,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             mark_dirty
);

  logic [PFN_W-1:0] frame_q [ENTRIES];
  pte_flags_t       flags_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic cfg_hit;
    logic upd_hit;
    assign cfg_hit = wr_en && (wr_idx == IDX_W'(i));
    assign upd_hit = mark_en && (mark_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        frame_q[i] <= '0;
        flags_q[i] <= '0;
      end else if (cfg_hit) begin
        frame_q[i]         <= wr_frame;
        flags_q[i].present <= wr_present;
        flags_q[i].can_rd  <= wr_rd;
        flags_q[i].can_wr  <= wr_wr;
        flags_q[i].can_ex  <= wr_ex;
        flags_q[i].nocache <= wr_nocache;
        flags_q[i].used    <= 1'b0;
        flags_q[i].dirty   <= 1'b0;
      end else if (upd_hit) begin
        flags_q[i].used <= 1'b1;
        if (mark_dirty) flags_q[i].dirty <= 1'b1;
      end
    end
  end

  assign lk_frame = frame_q[lk_idx];
  assign lk_flags = flags_q[lk_idx];

endmodule

// File: rtl/xlate_eval.sv
module xlate_eval
  import xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PFN_W = 3,
  localparam int PA_W = OFF_W + PFN_W
) (
  input  pte_flags_t       ent_flags,
  input  logic [PFN_W-1:0] ent_frame,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       kind,
  output logic             miss,
  output logic             denied,
  output logic             ok,
  output logic [PA_W-1:0]  paddr,
  output logic             used_after,
  output logic             dirty_after
);

  logic [31:0] joined;

  always_comb begin
    miss   = !ent_flags.present;
    denied = ent_flags.present && !kind_permitted(ent_flags, kind);
    ok     = !miss && !denied;
    joined = join_frame(16'(ent_frame), 16'(offset), OFF_W);
    paddr  = ok ? joined[PA_W-1:0] : '0;
    used_after  = ent_flags.used  | ok;
    dirty_after = ent_flags.dirty | (ok && (kind == ACC_WRITE));
  end

endmodule

// File: rtl/pgtbl_xlate.sv
module pgtbl_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int PFN_W = 3,
  localparam int VPN_W   = VA_W - OFF_W,
  localparam int ENTRIES = 1 << VPN_W,
  localparam int PA_W    = OFF_W + PFN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [VPN_W-1:0] cfg_idx,
  input  logic [PFN_W-1:0] cfg_frame,
  input  logic             cfg_present,
  input  logic             cfg_rd,
  input  logic             cfg_wr,
  input  logic             cfg_ex,
  input  logic             cfg_nocache,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_pgfault,
  output logic             rsp_protfault,
  output logic             rsp_nocache,
  output logic             rsp_used,
  output logic             rsp_dirty
);

  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] offset;
  logic [PFN_W-1:0] lk_frame;
  pte_flags_t       lk_flags;

  // Named internal events, visible to the bound checker.
  logic             xl_miss;
  logic             xl_denied;
  logic             xl_ok;
  logic [PA_W-1:0]  xl_paddr;
  logic             xl_used;
  logic             xl_dirty;
  logic             xl_commit;

  assign vpn       = req_vaddr[VA_W-1:OFF_W];
  assign offset    = req_vaddr[OFF_W-1:0];
  assign xl_commit = req_valid && xl_ok;

  pt_store #(
    .ENTRIES (ENTRIES),
    .PFN_W   (PFN_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_idx     (cfg_idx),
    .wr_frame   (cfg_frame),
    .wr_present (cfg_present),
    .wr_rd      (cfg_rd),
    .wr_wr      (cfg_wr),
    .wr_ex      (cfg_ex),
    .wr_nocache (cfg_nocache),
    .lk_idx     (vpn),
    .lk_frame   (lk_frame),
    .lk_flags   (lk_flags),
    .mark_en    (xl_commit),
    .mark_idx   (vpn),
    .mark_dirty (req_kind == ACC_WRITE)
  );

  xlate_eval #(
    .OFF_W (OFF_W),
    .PFN_W (PFN_W)
  ) u_eval (
    .ent_flags   (lk_flags),
    .ent_frame   (lk_frame),
    .offset      (offset),
    .kind        (req_kind),
    .miss        (xl_miss),
    .denied      (xl_denied),
    .ok          (xl_ok),
    .paddr       (xl_paddr),
    .used_after  (xl_used),
    .dirty_after (xl_dirty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_pgfault   <= 1'b0;
      rsp_protfault <= 1'b0;
      rsp_nocache   <= 1'b0;
      rsp_used      <= 1'b0;
      rsp_dirty     <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_paddr     <= req_valid ? xl_paddr : '0;
      rsp_pgfault   <= req_valid && xl_miss;
      rsp_protfault <= req_valid && xl_denied;
      rsp_nocache   <= req_valid && xl_ok && lk_flags.nocache;
      rsp_used      <= req_valid && xl_used;
      rsp_dirty     <= req_valid && xl_dirty;
    end
  end

endmodule

// File: rtl/pgtbl_xlate_sva.sv
module pgtbl_xlate_sva #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int PA_W  = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic [1:0]      req_kind,
  input logic            xl_ok,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_pgfault,
  input logic            rsp_protfault,
  input logic            rsp_nocache,
  input logic            rsp_used,
  input logic            rsp_dirty
);

  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_pgfault && !rsp_protfault && rsp_paddr == '0);

  p_single_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_pgfault, rsp_protfault}));

  p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_pgfault || rsp_protfault) |-> rsp_paddr == '0 && !rsp_nocache);

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xl_ok |=> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  p_ok_no_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xl_ok |=> !rsp_pgfault && !rsp_protfault);

  p_used_on_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xl_ok |=> rsp_used);

  p_dirty_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xl_ok && req_kind == 2'd1 |=> rsp_dirty);

  p_rsvd_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd3 |=> rsp_pgfault || rsp_protfault);

endmodule

bind pgtbl_xlate pgtbl_xlate_sva #(
  .VA_W  (VA_W),
  .OFF_W (OFF_W),
  .PA_W  (PA_W)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_vaddr     (req_vaddr),
  .req_kind      (req_kind),
  .xl_ok         (xl_ok),
  .rsp_valid     (rsp_valid),
  .rsp_paddr     (rsp_paddr),
  .rsp_pgfault   (rsp_pgfault),
  .rsp_protfault (rsp_protfault),
  .rsp_nocache   (rsp_nocache),
  .rsp_used      (rsp_used),
  .rsp_dirty     (rsp_dirty)
);

// File: tb/pgtbl_xlate_tb_top.sv
`timescale 1ns/1ps
module pgtbl_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [2:0]  cfg_frame = '0;
  logic        cfg_present = 1'b0;
  logic        cfg_rd = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_ex = 1'b0;
  logic        cfg_nocache = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [14:0] rsp_paddr;
  logic        rsp_pgfault;
  logic        rsp_protfault;
  logic        rsp_nocache;
  logic        rsp_used;
  logic        rsp_dirty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side model of the table.
  int m_frame [16];
  bit m_pres [16];
  bit m_rd [16];
  bit m_wr [16];
  bit m_ex [16];
  bit m_nc [16];
  bit m_used [16];
  bit m_dirty [16];

  always #5 clk = ~clk;

  pgtbl_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_frame(cfg_frame),
    .cfg_present(cfg_present), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_ex(cfg_ex), .cfg_nocache(cfg_nocache),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_pgfault(rsp_pgfault),
    .rsp_protfault(rsp_protfault), .rsp_nocache(rsp_nocache),
    .rsp_used(rsp_used), .rsp_dirty(rsp_dirty)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic program_entry(input int idx, input int fr, input bit p, input bit r,
                               input bit w, input bit x, input bit nc);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_frame = 3'(fr);
    cfg_present = p; cfg_rd = r; cfg_wr = w; cfg_ex = x; cfg_nocache = nc;
    @(negedge clk);
    cfg_we = 1'b0;
    m_frame[idx] = fr; m_pres[idx] = p; m_rd[idx] = r; m_wr[idx] = w;
    m_ex[idx] = x; m_nc[idx] = nc; m_used[idx] = 1'b0; m_dirty[idx] = 1'b0;
  endtask

  // Drive one request; sample the response one cycle later; compare to the model.
  task automatic access(input int va, input int kind);
    int pg; bit allowed; bit e_pg; bit e_prot; int e_pa; bit e_nc;
    string ftag;
    pg = (va / 4096) % 16;
    req_valid = 1'b1; req_vaddr = 16'(va); req_kind = 2'(kind);
    @(negedge clk);
    req_valid = 1'b0;
    allowed = (kind == 0) ? m_rd[pg] : (kind == 1) ? m_wr[pg] : (kind == 2) ? m_ex[pg] : 1'b0;
    e_pg = !m_pres[pg];
    e_prot = m_pres[pg] && !allowed;
    e_pa = 0; e_nc = 1'b0;
    if (!e_pg && !e_prot) begin
      e_pa = m_frame[pg] * 4096 + (va % 4096);
      e_nc = m_nc[pg];
      m_used[pg] = 1'b1;
      if (kind == 1) m_dirty[pg] = 1'b1;
    end
    ftag = (e_pg && !allowed) ? "R6" : e_pg ? "R4" : "R5";
    check(rsp_valid == 1'b1, "R2 valid", int'(rsp_valid), 1);
    check(rsp_pgfault == e_pg, {ftag, " pgfault"}, int'(rsp_pgfault), int'(e_pg));
    check(rsp_protfault == e_prot, {ftag, " protfault"}, int'(rsp_protfault), int'(e_prot));
    check(int'(rsp_paddr) == e_pa, "R3 paddr", int'(rsp_paddr), e_pa);
    check(rsp_nocache == e_nc, "R11 nocache", int'(rsp_nocache), int'(e_nc));
    check(rsp_used == m_used[pg], (e_pg || e_prot) ? "R9 used" : "R7 used",
          int'(rsp_used), int'(m_used[pg]));
    check(rsp_dirty == m_dirty[pg], (e_pg || e_prot) ? "R9 dirty" : "R8 dirty",
          int'(rsp_dirty), int'(m_dirty[pg]));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_frame[i] = 0; m_pres[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
      m_ex[i] = 0; m_nc[i] = 0; m_used[i] = 0; m_dirty[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: quiet after reset, every entry absent.
    check(rsp_valid == 1'b0, "R1 rsp_valid idle", int'(rsp_valid), 0);
    req_valid = 1'b1; req_vaddr = 16'h5ABC; req_kind = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_pgfault == 1'b1, "R1 pgfault after reset", int'(rsp_pgfault), 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 no pulse when idle", int'(rsp_valid), 0);

    // Exhaustive sweep: every page x every present/permission combo x every kind.
    for (int vpn = 0; vpn < 16; vpn++) begin
      for (int combo = 0; combo < 16; combo++) begin
        program_entry(vpn, (vpn * 3 + combo) % 8, combo[0], combo[1], combo[2], combo[3],
                      combo[0] ^ vpn[0]);
        for (int kind = 0; kind < 4; kind++) begin
          access(vpn * 4096 + ((vpn * 257 + combo * 31 + kind * 1000) % 4096), kind);
        end
      end
    end

    // R10: rewrite clears used and dirty; refusal keeps them cleared.
    program_entry(7, 5, 1, 1, 1, 0, 0);
    access(7 * 4096 + 16, 1);
    check(rsp_dirty == 1'b1, "R8 dirty set before rewrite", int'(rsp_dirty), 1);
    program_entry(7, 2, 1, 1, 0, 0, 1);
    access(7 * 4096 + 20, 2);
    check(rsp_used == 1'b0 && rsp_dirty == 1'b0, "R10 flags cleared by rewrite",
          int'({rsp_used, rsp_dirty}), 0);
    access(7 * 4096 + 20, 0);
    check(int'(rsp_paddr) == 2 * 4096 + 20, "R10 frame replaced", int'(rsp_paddr), 2 * 4096 + 20);

    // R2: back-to-back requests across pages.
    program_entry(1, 6, 1, 1, 1, 1, 0);
    program_entry(2, 3, 1, 1, 0, 0, 0);
    access(1 * 4096 + 4095, 1);
    access(2 * 4096 + 0, 0);
    access(2 * 4096 + 1, 1);
    access(1 * 4096 + 7, 2);
    check(rsp_valid == 1'b1, "R2 back-to-back still valid", int'(rsp_valid), 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 pulse ends", int'(rsp_valid), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule